// File: doc/BRIEF.md
# Byte and Halfword Swap Unit

This unit reorders the bytes of a 32-bit operand in one of three ways. It can swap the two bytes inside each halfword, reverse all four bytes of the word, or exchange the two halfwords. A two-bit select picks the operation, and a valid strobe marks each request. The result leaves through a register stage one clock later, together with a matching valid, an illegal-select indication and a 4-bit flag vector. A status register outside the unit captures the flags.

The carry flag is not an arithmetic carry. It reports whether the reordered word contains a zero byte or a zero halfword, which helps software scan strings a word at a time. Overflow is always cleared. Zero and sign describe the result word.

Top module: `lane_swap_unit`

## Requirements
- R1: With select 00 and valid high, the result one clock later swaps the bytes inside each halfword: result bits 31:24 take source 23:16, 23:16 take 31:24, 15:8 take 7:0, and 7:0 take 15:8.
- R2: With select 01 and valid high, the result one clock later reverses the byte order: source byte 3 lands in result byte 0, byte 2 in byte 1, byte 1 in byte 2, and byte 0 in byte 3.
- R3: With select 10 and valid high, the result one clock later holds the source with its upper and lower 16-bit halves exchanged.
- R4: With select 11 and valid high, the result one clock later equals the source unchanged and outIllegal is 1. For selects 00, 01 and 10, outIllegal is 0.
- R5: In flag vector bit 0 (zero), a 1 means the 32-bit result is zero. Flag vector bit 1 (sign) equals result bit 31. Both hold for every select.
- R6: Flag vector bit 3 (overflow) is always 0.
- R7: Flag vector bit 2 (carry) is set by a different test for each select:
  - select 01: any of the four result bytes is zero;
  - select 10: either 16-bit half of the result is zero;
  - select 00: result bits 7:0 are zero;
  - select 11: carry is 0.
- R8: outValid equals inValid delayed by exactly one clock. While inValid is low, outData and outFlags keep their previous values.
- R9: Synchronous active-high reset clears outValid, outData, outFlags and outIllegal to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| inOp | input | 2 | Operation select: 00 halfword byte swap, 01 byte reverse, 10 halfword exchange, 11 illegal (pass-through) |
| inData | input | 32 | Source operand |
| outValid | output | 1 | Result valid, one clock after inValid |
| outData | output | 32 | Reordered result |
| outFlags | output | 4 | Bit 0 zero, bit 1 sign, bit 2 carry, bit 3 overflow |
| outIllegal | output | 1 | Select 11 was requested |

## Verification
The assertions take inValid and inOp as known, settled values at each rising edge, with reset held from the first edge. The mode-mapping properties compare the result with the operand sampled one edge earlier, so they require inData to be stable at the edge where valid is sampled. The bench changes inputs only on falling edges and keeps reset high through the first edges, which keeps every input within those assumptions.

// File: rtl/lane_swap_pkg.sv
package lane_swap_pkg;

  typedef enum logic [1:0] {
    OP_HALF_BSWAP = 2'b00,
    OP_WORD_BREV  = 2'b01,
    OP_HALF_XCHG  = 2'b10,
    OP_PASS       = 2'b11
  } swapOp_e;

  typedef struct packed {
    logic load;
    logic selHalfBswap;
    logic selWordBrev;
    logic selHalfXchg;
    logic selPass;
  } swapStrobe_t;

  localparam int FLAG_W    = 4;
  localparam int FLAG_ZERO = 0;
  localparam int FLAG_SIGN = 1;
  localparam int FLAG_CARRY = 2;
  localparam int FLAG_OVF  = 3;

endpackage

// File: rtl/lane_swap_ctrl.sv
module lane_swap_ctrl
  import lane_swap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [1:0]  inOp,
  output swapStrobe_t strobe
);

  swapOp_e opSel;

  always_comb begin
    opSel               = swapOp_e'(inOp);
    strobe.load         = inValid;
    strobe.selHalfBswap = inValid && (opSel == OP_HALF_BSWAP);
    strobe.selWordBrev  = inValid && (opSel == OP_WORD_BREV);
    strobe.selHalfXchg  = inValid && (opSel == OP_HALF_XCHG);
    strobe.selPass      = inValid && (opSel == OP_PASS);
  end

  // R4: exactly one mode select accompanies each accepted request
  a_r4_one_select: assert property (@(posedge clk) disable iff (rst)
    strobe.load |-> ($countones({strobe.selHalfBswap, strobe.selWordBrev,
                                 strobe.selHalfXchg, strobe.selPass}) == 1));

  // R8: no mode select without a request
  a_r8_idle_no_select: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |-> ({strobe.selHalfBswap, strobe.selWordBrev,
                       strobe.selHalfXchg, strobe.selPass} == 4'b0000));

endmodule

// File: rtl/lane_swap_dp.sv
module lane_swap_dp
  import lane_swap_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  swapStrobe_t             strobe,
  input  logic [LANE_W*LANES-1:0] srcData,
  output logic [LANE_W*LANES-1:0] resData,
  output logic [FLAG_W-1:0]       resFlags,
  output logic                    resValid,
  output logic                    resIllegal
);

  localparam int DATA_W = LANE_W * LANES;
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] pairSwap;
  logic [DATA_W-1:0] revWord;
  logic [DATA_W-1:0] halfXchg;
  logic [LANES-1:0]  laneZero;
  logic [DATA_W-1:0] nextData;
  logic              nextCarry;
  logic [FLAG_W-1:0] nextFlags;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign revWord[g*LANE_W +: LANE_W]  = srcData[(LANES-1-g)*LANE_W +: LANE_W];
    assign pairSwap[g*LANE_W +: LANE_W] = srcData[(g ^ 1)*LANE_W +: LANE_W];
    assign laneZero[g] = (revWord[g*LANE_W +: LANE_W] == '0);
  end

  assign halfXchg = {srcData[HALF_W-1:0], srcData[DATA_W-1:HALF_W]};

  always_comb begin
    if (strobe.selHalfBswap) begin
      nextData  = pairSwap;
      nextCarry = (pairSwap[LANE_W-1:0] == '0);
    end else if (strobe.selWordBrev) begin
      nextData  = revWord;
      nextCarry = |laneZero;
    end else if (strobe.selHalfXchg) begin
      nextData  = halfXchg;
      nextCarry = (halfXchg[HALF_W-1:0] == '0) || (halfXchg[DATA_W-1:HALF_W] == '0);
    end else begin
      nextData  = srcData;
      nextCarry = 1'b0;
    end
    nextFlags             = '0;
    nextFlags[FLAG_ZERO]  = (nextData == '0);
    nextFlags[FLAG_SIGN]  = nextData[DATA_W-1];
    nextFlags[FLAG_CARRY] = nextCarry;
    nextFlags[FLAG_OVF]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid   <= 1'b0;
      resIllegal <= 1'b0;
      resData    <= '0;
      resFlags   <= '0;
    end else begin
      resValid   <= strobe.load;
      resIllegal <= strobe.selPass;
      if (strobe.load) begin
        resData  <= nextData;
        resFlags <= nextFlags;
      end
    end
  end

  // R1: outer lanes of each halfword swapped (checked on top and bottom lanes)
  a_r1_half_bswap: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.selHalfBswap) |=>
      (resData[LANE_W-1:0] == $past(srcData[2*LANE_W-1:LANE_W])) &&
      (resData[DATA_W-1 -: LANE_W] == $past(srcData[DATA_W-LANE_W-1 -: LANE_W])));

  // R2: end lanes trade places under full reversal
  a_r2_word_reverse: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.selWordBrev) |=>
      (resData[LANE_W-1:0] == $past(srcData[DATA_W-1 -: LANE_W])) &&
      (resData[DATA_W-1 -: LANE_W] == $past(srcData[LANE_W-1:0])));

  // R3: halves exchanged
  a_r3_half_exchange: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.selHalfXchg) |=>
      (resData[DATA_W-1:HALF_W] == $past(srcData[HALF_W-1:0])) &&
      (resData[HALF_W-1:0] == $past(srcData[DATA_W-1:HALF_W])));

  // R4: illegal select passes the operand and raises the indication
  a_r4_pass_illegal: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.selPass) |=> (resData == $past(srcData)) && resIllegal);

  // R5: zero and sign describe the registered result
  a_r5_zero_sign: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (resFlags[FLAG_ZERO] == (resData == '0)) &&
                 (resFlags[FLAG_SIGN] == resData[DATA_W-1]));

  // R6: overflow never set
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !resFlags[FLAG_OVF]);

  // R7: carry in exchange mode reports a zero half
  a_r7_xchg_carry: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.selHalfXchg) |=>
      (resFlags[FLAG_CARRY] == ((resData[HALF_W-1:0] == '0) || (resData[DATA_W-1:HALF_W] == '0))));

  // R8: idle cycle drops valid and holds the result
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> !resValid && $stable(resData) && $stable(resFlags));

endmodule

// File: rtl/lane_swap_unit.sv
module lane_swap_unit
  import lane_swap_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [1:0]              inOp,
  input  logic [LANE_W*LANES-1:0] inData,
  output logic                    outValid,
  output logic [LANE_W*LANES-1:0] outData,
  output logic [FLAG_W-1:0]       outFlags,
  output logic                    outIllegal
);

  swapStrobe_t strobe;

  lane_swap_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inOp    (inOp),
    .strobe  (strobe)
  );

  lane_swap_dp #(.LANE_W(LANE_W), .LANES(LANES)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .srcData    (inData),
    .resData    (outData),
    .resFlags   (outFlags),
    .resValid   (outValid),
    .resIllegal (outIllegal)
  );

endmodule

// File: tb/lane_swap_unit_tb.sv
`timescale 1ns/1ps
module lane_swap_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  inOp = 2'b00;
  logic [31:0] inData = '0;
  logic        outValid;
  logic [31:0] outData;
  logic [3:0]  outFlags;
  logic        outIllegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lane_swap_unit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inOp(inOp), .inData(inData),
    .outValid(outValid), .outData(outData), .outFlags(outFlags), .outIllegal(outIllegal)
  );

  localparam int NV = 13;
  // flags: bit0 zero, bit1 sign, bit2 carry, bit3 overflow
  localparam logic [1:0]  VOP  [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd1,
                                        2'd2, 2'd2, 2'd2, 2'd3, 2'd3, 2'd0};
  localparam logic [31:0] VIN  [NV] = '{32'h11223344, 32'h00FF1200, 32'hAB0000CD,
                                        32'h11223344, 32'h80000001, 32'h000000F0, 32'h00000000,
                                        32'h12345678, 32'h0000ABCD, 32'h00010100,
                                        32'h80000000, 32'h00000000, 32'h00000000};
  localparam logic [31:0] VOUT [NV] = '{32'h22114433, 32'hFF000012, 32'h00ABCD00,
                                        32'h44332211, 32'h01000080, 32'hF0000000, 32'h00000000,
                                        32'h56781234, 32'hABCD0000, 32'h01000001,
                                        32'h80000000, 32'h00000000, 32'h00000000};
  localparam logic [3:0]  VFLG [NV] = '{4'h0, 4'h2, 4'h4, 4'h0, 4'h4, 4'h6, 4'h5,
                                        4'h0, 4'h6, 4'h0, 4'h2, 4'h1, 4'h5};
  localparam string       VREQ [NV] = '{"R1 R7", "R1 R5", "R1 R7", "R2", "R2 R7", "R2 R5 R7",
                                        "R2 R5 R7", "R3", "R3 R5 R7", "R3 R7",
                                        "R4 R5", "R4 R5", "R1 R5 R7"};

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9", "outValid after reset", {31'b0, outValid}, 32'd0);
    check("R9", "outFlags after reset", {28'b0, outFlags}, 32'd0);
    check("R9", "outIllegal after reset", {31'b0, outIllegal}, 32'd0);
    check("R9", "outData after reset", outData, 32'd0);
    rst = 1'b0;

    // table walk, back to back requests
    for (int i = 0; i < NV; i++) begin
      inValid = 1'b1;
      inOp    = VOP[i];
      inData  = VIN[i];
      @(negedge clk);
      check("R8", "outValid", {31'b0, outValid}, 32'd1);
      check(VREQ[i], "outData", outData, VOUT[i]);
      check(VREQ[i], "outFlags", {28'b0, outFlags}, {28'b0, VFLG[i]});
      check("R4 R6", "outIllegal", {31'b0, outIllegal}, {31'b0, (VOP[i] == 2'd3)});
    end

    // R8: idle cycle holds result, drops valid
    inValid = 1'b1; inOp = 2'd1; inData = 32'h0A0B0C0D;
    @(negedge clk);
    inValid = 1'b0; inOp = 2'd2; inData = 32'h00000000;
    @(negedge clk);
    check("R8", "outValid idle", {31'b0, outValid}, 32'd0);
    check("R8", "outData held", outData, 32'h0D0C0B0A);
    check("R8", "outFlags held", {28'b0, outFlags}, 32'd0);
    @(negedge clk);
    check("R8", "outData held two idles", outData, 32'h0D0C0B0A);

    // R8: single pulse gives single valid
    inValid = 1'b1; inOp = 2'd3; inData = 32'hFFFFFFFF;
    @(negedge clk);
    inValid = 1'b0;
    check("R4", "pass data", outData, 32'hFFFFFFFF);
    check("R4 R7", "pass flags", {28'b0, outFlags}, 32'h2);
    @(negedge clk);
    check("R8", "valid falls after pulse", {31'b0, outValid}, 32'd0);

    // R9: reset in mid-stream
    inValid = 1'b1; inOp = 2'd3; inData = 32'h00000000;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9", "outValid mid reset", {31'b0, outValid}, 32'd0);
    check("R9", "outFlags mid reset", {28'b0, outFlags}, 32'd0);
    check("R9", "outIllegal mid reset", {31'b0, outIllegal}, 32'd0);
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule